// File: doc/BRIEF.md
# Instruction Exception Privilege Classifier

This block sits at the issue stage of a processor. Each instruction arrives already decoded into a class code, together with its special-register number field. The block also receives the current privilege bit, the floating-point exception enable, a floating-point exception report and a trap-condition result. From these it picks exactly one exception cause. The possible causes are none, illegal instruction, privileged instruction, system call, trap and floating-point program exception. It also raises a no-op flag when a supervisor writes to a read-only special register; that write is then dropped quietly instead of faulting.

Access to special registers is checked per register number. A parameter table marks which numbers exist, which are supervisor-only and which are read-only. A separate short list holds the valid time-base read numbers. Results leave through a registered valid/ready stage one cycle after acceptance. The input is held off while an unconsumed result is stalled.

Top module: `xcp_classifier`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An input accepted when `in_valid` and `in_ready` are both 1 appears on `out_valid`/`out_cause`/`out_nop` on the next clock edge. When no input is accepted and the result is consumed, `out_valid` drops.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the outputs hold their values.
- R4: Class 1 (supervisor-only operations) gives cause 2 (privileged) when `in_user` is 1 and cause 0 (none) when `in_user` is 0.
- R5: Class 2 (write special register) or class 3 (read special register) with a number not in the table gives cause 1 (illegal) in either mode.
- R6: A class 2 or 3 access to a listed supervisor-only number gives cause 2 in user mode. An access to a listed user-level number gives cause 0 in either mode. With the default table, numbers 1, 8 and 9 are user-level; 26, 27, 272, 287 and 1009 are supervisor-only.
- R7: A class 2 write to a read-only number (defaults 287 and 1009) with `in_user` at 0 gives cause 0 and `out_nop` at 1. A class 3 read of the same number gives `out_nop` at 0.
- R8: Class 4 (time-base read) gives cause 0 for numbers 268 or 269 and cause 1 for any other number.
- R9: Class 5 (system call) always gives cause 3. Class 6 (trap) gives cause 4 when `in_trap_hit` is 1 and cause 0 otherwise.
- R10: Class 7 (floating-point) gives cause 5 only when both `in_fp_exc` and `in_fp_en` are 1; otherwise cause 0. Class 0 (ordinary) gives cause 0.
- R11: Class codes 8 to 15 give cause 1 whatever the other inputs are.
- R12: When `out_valid` is 1 and `out_nop` is 1, `out_cause` is 0. Priority from highest is: illegal class, illegal register number, privilege violation, system call, trap, floating-point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted this cycle when valid |
| in_class | input | 4 | Decoded instruction class |
| in_sprn | input | 10 | Special-register / time-base number field |
| in_user | input | 1 | Privilege bit, 1 = user mode |
| in_fp_en | input | 1 | Floating-point exceptions enabled |
| in_fp_exc | input | 1 | Floating-point instruction reports an exception |
| in_trap_hit | input | 1 | Trap condition satisfied |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_cause | output | 3 | 0 none, 1 illegal, 2 privileged, 3 system call, 4 trap, 5 fp program |
| out_nop | output | 1 | Register write suppressed |

## Verification
Directed instructions walk every class in both privilege modes. Each register-access class gets listed user numbers, listed supervisor numbers, read-only numbers and unlisted numbers, which separates the illegal-number path from the privilege path and from the no-op path. Trap and floating-point instructions are driven with their condition and enable inputs in all combinations, so a missing enable gate shows up. A long run of mixed instructions under an irregular `out_ready` pattern is then compared cycle by cycle against a queue-based model. That run catches lost, duplicated or changed results under back-pressure.

// File: rtl/xcp_pkg.sv
package xcp_pkg;

  localparam logic [3:0] CL_PLAIN = 4'd0;
  localparam logic [3:0] CL_SUPV  = 4'd1;
  localparam logic [3:0] CL_WRSR  = 4'd2;
  localparam logic [3:0] CL_RDSR  = 4'd3;
  localparam logic [3:0] CL_TBRD  = 4'd4;
  localparam logic [3:0] CL_SCALL = 4'd5;
  localparam logic [3:0] CL_TRAP  = 4'd6;
  localparam logic [3:0] CL_FPOP  = 4'd7;

  typedef enum logic [2:0] {
    XC_NONE    = 3'd0,
    XC_ILLEGAL = 3'd1,
    XC_PRIV    = 3'd2,
    XC_SCALL   = 3'd3,
    XC_TRAP    = 3'd4,
    XC_FPPROG  = 3'd5
  } cause_e;

  typedef struct packed {
    logic bad_op;
    logic bad_reg;
    logic priv;
    logic scall;
    logic trap;
    logic fp;
  } viol_t;

  function automatic cause_e rank_cause(input viol_t v);
    if (v.bad_op)       return XC_ILLEGAL;
    else if (v.bad_reg) return XC_ILLEGAL;
    else if (v.priv)    return XC_PRIV;
    else if (v.scall)   return XC_SCALL;
    else if (v.trap)    return XC_TRAP;
    else if (v.fp)      return XC_FPPROG;
    return XC_NONE;
  endfunction

endpackage

// File: rtl/xcp_num_match.sv
module xcp_num_match #(
  parameter int          W     = 10,
  parameter int          N     = 8,
  parameter logic [N*W-1:0] NUMS = '0
) (
  input  logic [W-1:0] num,
  output logic [N-1:0] hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hit_vec[i] = (num == NUMS[i*W +: W]);
  end
endmodule

// File: rtl/xcp_cause_select.sv
module xcp_cause_select
  import xcp_pkg::*;
(
  input  logic [3:0] cls,
  input  logic       user,
  input  logic       fp_en,
  input  logic       fp_exc,
  input  logic       trap_hit,
  input  logic       spr_hit,
  input  logic       spr_supv,
  input  logic       spr_ro,
  input  logic       tb_hit,
  output viol_t      viol,
  output cause_e     cause,
  output logic       nop
);
  logic is_sr;

  always_comb begin
    is_sr        = (cls == CL_WRSR) || (cls == CL_RDSR);
    viol.bad_op  = cls[3];
    viol.bad_reg = (is_sr && !spr_hit) || ((cls == CL_TBRD) && !tb_hit);
    viol.priv    = user && ((cls == CL_SUPV) || (is_sr && spr_hit && spr_supv));
    viol.scall   = (cls == CL_SCALL);
    viol.trap    = (cls == CL_TRAP) && trap_hit;
    viol.fp      = (cls == CL_FPOP) && fp_exc && fp_en;
    cause        = rank_cause(viol);
    nop          = (cls == CL_WRSR) && spr_hit && spr_ro && !user;
  end
endmodule

// File: rtl/xcp_result_reg.sv
module xcp_result_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));
  p_stall_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/xcp_classifier.sv
module xcp_classifier
  import xcp_pkg::*;
#(
  parameter int SPRN_W = 10,
  parameter int N_SPR  = 8,
  parameter logic [N_SPR*SPRN_W-1:0] SPR_NUMS =
    {10'd1009, 10'd287, 10'd272, 10'd27, 10'd26, 10'd9, 10'd8, 10'd1},
  parameter logic [N_SPR-1:0] SPR_SUPV = 8'b1111_1000,
  parameter logic [N_SPR-1:0] SPR_RO   = 8'b1100_0000,
  parameter int N_TB = 2,
  parameter logic [N_TB*SPRN_W-1:0] TB_NUMS = {10'd269, 10'd268}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_class,
  input  logic [SPRN_W-1:0] in_sprn,
  input  logic              in_user,
  input  logic              in_fp_en,
  input  logic              in_fp_exc,
  input  logic              in_trap_hit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_cause,
  output logic              out_nop
);
  localparam int RES_W = $bits(cause_e) + 1;

  logic [N_SPR-1:0] spr_vec;
  logic [N_TB-1:0]  tb_vec;
  logic             spr_hit, spr_supv, spr_ro, tb_hit;
  viol_t            viol;
  cause_e           cause_c;
  logic             nop_c;
  logic [RES_W-1:0] res_q;

  xcp_num_match #(.W(SPRN_W), .N(N_SPR), .NUMS(SPR_NUMS)) u_spr (
    .num(in_sprn), .hit_vec(spr_vec));
  xcp_num_match #(.W(SPRN_W), .N(N_TB), .NUMS(TB_NUMS)) u_tb (
    .num(in_sprn), .hit_vec(tb_vec));

  assign spr_hit  = |spr_vec;
  assign spr_supv = |(spr_vec & SPR_SUPV);
  assign spr_ro   = |(spr_vec & SPR_RO);
  assign tb_hit   = |tb_vec;

  xcp_cause_select u_sel (
    .cls(in_class), .user(in_user), .fp_en(in_fp_en), .fp_exc(in_fp_exc),
    .trap_hit(in_trap_hit), .spr_hit(spr_hit), .spr_supv(spr_supv),
    .spr_ro(spr_ro), .tb_hit(tb_hit), .viol(viol), .cause(cause_c),
    .nop(nop_c));

  xcp_result_reg #(.W(RES_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d({nop_c, cause_c}), .out_valid(out_valid), .out_ready(out_ready),
    .q(res_q));

  assign out_cause = res_q[RES_W-2:0];
  assign out_nop   = res_q[RES_W-1];

  logic accept;
  assign accept = in_valid && in_ready;

  p_user_supv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_user && in_class == CL_SUPV) |=> out_cause == 3'd2);
  p_bad_class_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_class[3]) |=> out_cause == 3'd1);
  p_scall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_class == CL_SCALL) |=> out_cause == 3'd3);
  p_fp_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_class == CL_FPOP && !in_fp_en) |=> out_cause == 3'd0);
  p_nop_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nop) |-> out_cause == 3'd0);
  p_nop_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_user) |=> !out_nop);
endmodule

// File: tb/xcp_classifier_test.sv
module xcp_classifier_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_user = 0, in_fp_en = 0, in_fp_exc = 0;
  logic in_trap_hit = 0, out_valid, out_ready = 1, out_nop;
  logic [3:0] in_class = 0;
  logic [9:0] in_sprn = 0;
  logic [2:0] out_cause;

  always #5 clk = ~clk;

  xcp_classifier uut (.*);

  typedef struct {int cause; bit nop; string tag;} item_t;
  item_t q[$];
  int tests = 0, fails = 0;
  bit stall_mode = 0;
  int cyc = 0;
  bit done = 0;

  function automatic bit in_list(int v, int lst[]);
    foreach (lst[i]) if (lst[i] == v) return 1;
    return 0;
  endfunction

  function automatic item_t model(int c, int s, bit u, bit fe, bit fx, bit th, string tag);
    item_t it;
    int users[] = '{1, 8, 9};
    int supvs[] = '{26, 27, 272, 287, 1009};
    int ros[]   = '{287, 1009};
    int tbs[]   = '{268, 269};
    bit listed;
    it.tag = tag; it.nop = 0; it.cause = 0;
    listed = in_list(s, users) || in_list(s, supvs);
    if (c >= 8) it.cause = 1;
    else case (c)
      1: it.cause = u ? 2 : 0;
      2, 3: begin
        if (!listed) it.cause = 1;
        else if (u && in_list(s, supvs)) it.cause = 2;
        else begin
          it.cause = 0;
          it.nop = (c == 2) && !u && in_list(s, ros);
        end
      end
      4: it.cause = in_list(s, tbs) ? 0 : 1;
      5: it.cause = 3;
      6: it.cause = th ? 4 : 0;
      7: it.cause = (fx && fe) ? 5 : 0;
      default: it.cause = 0;
    endcase
    return it;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid === (q.size() != 0), "R2", "out_valid", out_valid, q.size() != 0);
    chk(in_ready === (q.size() == 0 || out_ready), "R3", "in_ready", in_ready,
        q.size() == 0 || out_ready);
    if (out_valid && q.size() != 0) begin
      chk(out_cause === q[0].cause[2:0], q[0].tag, "cause", out_cause, q[0].cause);
      chk(out_nop === q[0].nop, q[0].tag, "nop", out_nop, q[0].nop);
    end
  endtask

  task automatic step();
    bit fo, fi;
    item_t it;
    fo = (q.size() != 0) && out_ready;
    fi = in_valid && ((q.size() == 0) || out_ready);
    it = model(in_class, in_sprn, in_user, in_fp_en, in_fp_exc, in_trap_hit, cur_tag);
    @(posedge clk);
    if (fo) void'(q.pop_front());
    if (fi) q.push_back(it);
    @(negedge clk);
    cyc++;
    compare();
  endtask

  string cur_tag = "R2";

  task automatic pick_ready();
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  endtask

  task automatic issue(int c, int s, bit u, bit fe, bit fx, bit th, string tag);
    bit acc;
    in_class = c[3:0]; in_sprn = s[9:0]; in_user = u;
    in_fp_en = fe; in_fp_exc = fx; in_trap_hit = th; cur_tag = tag;
    in_valid = 1;
    do begin
      pick_ready();
      acc = (q.size() == 0) || out_ready;
      step();
    end while (!acc);
    in_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) begin
      pick_ready();
      step();
    end
    out_ready = 1;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(2_000_000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int pool[] = '{1, 8, 9, 26, 27, 272, 287, 1009, 268, 269, 0, 500, 1023};
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid === 1'b0, "R1", "out_valid idle", out_valid, 0);

    // R4 supervisor-only class
    issue(1, 0, 1, 0, 0, 0, "R4");
    issue(1, 0, 0, 0, 0, 0, "R4");
    // R5 unlisted register numbers
    issue(2, 500, 0, 0, 0, 0, "R5");
    issue(3, 1023, 1, 0, 0, 0, "R5");
    issue(3, 268, 0, 0, 0, 0, "R5");
    // R6 privilege per number
    issue(3, 26, 1, 0, 0, 0, "R6");
    issue(2, 272, 1, 0, 0, 0, "R6");
    issue(2, 8, 1, 0, 0, 0, "R6");
    issue(3, 9, 0, 0, 0, 0, "R6");
    issue(2, 27, 0, 0, 0, 0, "R6");
    // R7 read-only writes
    issue(2, 287, 0, 0, 0, 0, "R7");
    issue(2, 1009, 0, 0, 0, 0, "R7");
    issue(3, 1009, 0, 0, 0, 0, "R7");
    issue(2, 287, 1, 0, 0, 0, "R7");
    // R8 time-base list
    issue(4, 268, 1, 0, 0, 0, "R8");
    issue(4, 269, 0, 0, 0, 0, "R8");
    issue(4, 1, 1, 0, 0, 0, "R8");
    // R9 system call and trap
    issue(5, 0, 0, 0, 0, 0, "R9");
    issue(5, 0, 1, 1, 1, 1, "R9");
    issue(6, 0, 1, 0, 0, 1, "R9");
    issue(6, 0, 1, 0, 0, 0, "R9");
    // R10 floating point gating
    issue(7, 0, 0, 1, 1, 0, "R10");
    issue(7, 0, 0, 0, 1, 0, "R10");
    issue(7, 0, 1, 1, 0, 0, "R10");
    issue(0, 1009, 1, 1, 1, 1, "R10");
    // R11 classes outside the legal set
    issue(8, 26, 1, 1, 1, 1, "R11");
    issue(15, 0, 0, 0, 0, 0, "R11");
    issue(12, 287, 0, 0, 0, 0, "R11");
    drain();

    // R3 back-pressure with mixed traffic, R12 priority and nop cleanliness
    stall_mode = 1;
    for (int n = 0; n < 600; n++) begin
      int c = $urandom % 16;
      int s = (($urandom % 4) == 0) ? int'($urandom % 1024) : pool[$urandom % pool.size()];
      issue(c, s, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
            (n % 2 == 0) ? "R3" : "R12");
      if (($urandom % 8) == 0) begin
        pick_ready();
        step();
      end
    end
    drain();
    finish_run();
  end
endmodule